// File: doc/BRIEF.md
# Master Clock Rate Detector

This block works out which of four master-clock frequencies feeds a voice codec. Frame sync runs at 8 kHz, so the block counts master-clock cycles between successive rising edges of the frame sync. That count is matched against a short list of allowed ratios: 192 or 193 cycles for the 1.536/1.544 MHz clock, 256 for 2.048 MHz, 512 for 4.096 MHz and 1024 for 8.192 MHz. When the same rate has been measured over several frames in a row, the block raises a valid flag that power-up logic uses as its permission to start.

A second clock, free-running and independent of the master clock, checks that the master clock is still present. The master-clock domain keeps flipping a toggle bit. The reference domain synchronizes that bit and counts reference cycles since it last changed. If no change is seen for a programmable number of reference cycles (12 µs by default at 250 MHz), the block raises clock-lost. That flag drives global shutdown. It also resets the whole measurement path asynchronously, so once the clock returns the rate has to be qualified again from the start.

Top module: `clk_rate_detect`

## Requirements
- R1: After reset, rate_valid is 0, clk_lost is 0 and rate_code is 0.
- R2: A measured period of 192 or 193 master cycles maps to rate_code 0, 256 to code 1, 512 to code 2 and 1024 to code 3.
- R3: The first rising edge of fsync after reset or clock loss only starts the count. rate_valid goes to 1 one master cycle after the rising edge that completes the fourth consecutive period with the same rate code. That edge is the fifth rising edge.
- R4: A period that is not in the allowed set clears rate_valid at that edge and empties the qualification streak. This includes any period longer than 1024, where the counter saturates.
- R5: An allowed period whose rate code differs from the current candidate clears rate_valid. That period becomes the first of a new streak, so three further matching periods are needed before rate_valid returns.
- R6: While rate_valid stays 1, rate_code does not change.
- R7: Only the rising edge of fsync is measured. A frame sync held high for one, two or three master cycles gives the same result.
- R8: clk_lost rises once the master clock has not toggled for LOSS_LIMIT reference cycles. It falls again within a few reference cycles after toggling resumes.
- R9: While clk_lost is 1, rate_valid is 0. After the master clock returns, rate_valid stays 0 until a full qualification (R3) has completed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; also the frame-sync sampling clock |
| ref_clk | input | 1 | Free-running reference clock for loss detection |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | 8 kHz frame sync, synchronous to mclk |
| rate_code | output | 2 | Detected rate (0: 1.536/1.544, 1: 2.048, 2: 4.096, 3: 8.192 MHz) |
| rate_valid | output | 1 | Rate qualified; permits power-up |
| clk_lost | output | 1 | Master clock absent; reference-clock domain |

## Verification
Two functions can act in the same master cycle: a rising edge of fsync that would complete a streak, and a measurement that breaks it. The bench provokes this by sending a period of a different rate or an out-of-range period exactly on the frame that would have been the qualifying fourth. It then judges rate_valid and rate_code one cycle later against a bench-side streak model. Clock loss and qualification also overlap. The master clock is stopped while rate_valid is high, and the bench checks that valid falls with clk_lost and that the first frame sync after restart is treated only as a reference.

// File: rtl/clk_rate_pkg.sv
`timescale 1ns/1ps
package clk_rate_pkg;
  localparam int RATE_W    = 2;
  localparam int NUM_RATES = 1 << RATE_W;

  typedef logic [RATE_W-1:0] rate_code_t;

  // one period measurement, presented on a frame-sync rising edge
  typedef struct packed {
    logic       vld;
    logic       hit;
    rate_code_t code;
  } meas_t;
endpackage

// File: rtl/fs_period_counter.sv
`timescale 1ns/1ps
module fs_period_counter #(
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned SAT_VAL = 1025
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_cnt
);
  logic             fs_q;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fs_rise;
  logic             cnt_en;

  assign fs_rise = fsync & ~fs_q;

  // the count restarts at 1 on an edge so the next edge captures the full period
  always_comb begin
    cnt_en = fs_rise | (cnt_q != CNT_W'(SAT_VAL));
    cnt_d  = fs_rise ? CNT_W'(1) : cnt_q + 1'b1;
    seen_d = seen_q | fs_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fs_q   <= fsync;
      seen_q <= seen_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign meas_vld = fs_rise & seen_q;
  assign meas_cnt = cnt_q;
endmodule

// File: rtl/rate_classifier.sv
`timescale 1ns/1ps
module rate_classifier
  import clk_rate_pkg::*;
#(
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned RATIO_0  = 192,
  parameter int unsigned RATIO_0B = 193,
  parameter int unsigned RATIO_1  = 256,
  parameter int unsigned RATIO_2  = 512,
  parameter int unsigned RATIO_3  = 1024
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             hit,
  output rate_code_t       code
);
  localparam int unsigned RATIO_TBL [NUM_RATES] = '{RATIO_0, RATIO_1, RATIO_2, RATIO_3};

  logic [NUM_RATES-1:0] match;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_match
    if (g == 0) begin : g_alt
      assign match[g] = (cnt == CNT_W'(RATIO_TBL[g])) || (cnt == CNT_W'(RATIO_0B));
    end else begin : g_plain
      assign match[g] = (cnt == CNT_W'(RATIO_TBL[g]));
    end
  end

  always_comb begin
    hit  = |match;
    code = '0;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (match[i]) code = rate_code_t'(i);
    end
  end
endmodule

// File: rtl/rate_qualifier.sv
`timescale 1ns/1ps
module rate_qualifier
  import clk_rate_pkg::*;
#(
  parameter int unsigned QUAL_FRAMES = 4,
  parameter int unsigned STREAK_W    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  meas_t      meas,
  output logic       rate_valid,
  output rate_code_t rate_code
);
  rate_code_t          cand_q, cand_d;
  logic [STREAK_W-1:0] streak_q, streak_d;
  logic                valid_q, valid_d;
  logic                upd_en;

  always_comb begin
    upd_en   = meas.vld;
    cand_d   = cand_q;
    streak_d = streak_q;
    valid_d  = valid_q;
    if (!meas.hit) begin
      streak_d = '0;
      valid_d  = 1'b0;
    end else if ((streak_q == '0) || (meas.code != cand_q)) begin
      cand_d   = meas.code;
      streak_d = STREAK_W'(1);
      valid_d  = (QUAL_FRAMES == 1);
    end else if (streak_q != STREAK_W'(QUAL_FRAMES)) begin
      streak_d = streak_q + 1'b1;
      valid_d  = valid_q | (streak_q + 1'b1 == STREAK_W'(QUAL_FRAMES));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= '0;
      streak_q <= '0;
      valid_q  <= 1'b0;
    end else if (upd_en) begin
      cand_q   <= cand_d;
      streak_q <= streak_d;
      valid_q  <= valid_d;
    end
  end

  assign rate_valid = valid_q;
  assign rate_code  = cand_q;
endmodule

// File: rtl/mclk_loss_monitor.sv
`timescale 1ns/1ps
module mclk_loss_monitor #(
  parameter int unsigned LOSS_LIMIT = 3000,
  parameter int unsigned LOSS_W     = 12
) (
  input  logic mclk,
  input  logic mclk_arst_n,
  input  logic ref_clk,
  input  logic ref_rst_n,
  output logic clk_lost
);
  logic              tog_q;
  logic [2:0]        sync_q;
  logic              tog_seen;
  logic [LOSS_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              lost_q, lost_d;

  // free-running toggle in the master domain; only the primary reset touches it
  always_ff @(posedge mclk or negedge mclk_arst_n) begin
    if (!mclk_arst_n) tog_q <= 1'b0;
    else              tog_q <= ~tog_q;
  end

  assign tog_seen = sync_q[2] ^ sync_q[1];

  always_comb begin
    cnt_en = tog_seen | (cnt_q != LOSS_W'(LOSS_LIMIT));
    cnt_d  = tog_seen ? '0 : cnt_q + 1'b1;
    lost_d = ~tog_seen & (cnt_q >= LOSS_W'(LOSS_LIMIT - 1));
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], tog_q};
      lost_q <= lost_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign clk_lost = lost_q;
endmodule

// File: rtl/clk_rate_detect.sv
`timescale 1ns/1ps
module clk_rate_detect
  import clk_rate_pkg::*;
#(
  parameter int unsigned RATIO_0     = 192,
  parameter int unsigned RATIO_0B    = 193,
  parameter int unsigned RATIO_1     = 256,
  parameter int unsigned RATIO_2     = 512,
  parameter int unsigned RATIO_3     = 1024,
  parameter int unsigned QUAL_FRAMES = 4,
  parameter int unsigned LOSS_LIMIT  = 3000
) (
  input  logic       mclk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       fsync,
  output logic [1:0] rate_code,
  output logic       rate_valid,
  output logic       clk_lost
);
  localparam int unsigned MAX_A    = (RATIO_0 > RATIO_0B) ? RATIO_0 : RATIO_0B;
  localparam int unsigned MAX_B    = (RATIO_1 > RATIO_2) ? RATIO_1 : RATIO_2;
  localparam int unsigned MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CNT  = (MAX_C > RATIO_3) ? MAX_C : RATIO_3;
  localparam int unsigned SAT_VAL  = MAX_CNT + 1;
  localparam int unsigned CNT_W    = $clog2(SAT_VAL + 1);
  localparam int unsigned STREAK_W = $clog2(QUAL_FRAMES + 1);
  localparam int unsigned LOSS_W   = $clog2(LOSS_LIMIT + 1);

  logic [1:0]       ref_rs_q;
  logic             ref_rst_n;
  logic             m_arst_n;
  logic [1:0]       m_rs_q;
  logic             m_rst_n;
  logic             meas_vld;
  logic             meas_hit;
  rate_code_t       meas_code;
  logic [CNT_W-1:0] meas_cnt;
  meas_t            meas;
  rate_code_t       code_w;

  // reference domain: assert async, release on ref_clk
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_rs_q <= 2'b00;
    else        ref_rs_q <= {ref_rs_q[0], 1'b1};
  end
  assign ref_rst_n = ref_rs_q[1];

  // master domain: clock loss also resets it, release waits for mclk edges
  assign m_arst_n = rst_n & ~clk_lost;

  always_ff @(posedge mclk or negedge m_arst_n) begin
    if (!m_arst_n) m_rs_q <= 2'b00;
    else           m_rs_q <= {m_rs_q[0], 1'b1};
  end
  assign m_rst_n = m_rs_q[1];

  fs_period_counter #(
    .CNT_W   (CNT_W),
    .SAT_VAL (SAT_VAL)
  ) i_period (
    .clk      (mclk),
    .rst_n    (m_rst_n),
    .fsync    (fsync),
    .meas_vld (meas_vld),
    .meas_cnt (meas_cnt)
  );

  rate_classifier #(
    .CNT_W    (CNT_W),
    .RATIO_0  (RATIO_0),
    .RATIO_0B (RATIO_0B),
    .RATIO_1  (RATIO_1),
    .RATIO_2  (RATIO_2),
    .RATIO_3  (RATIO_3)
  ) i_class (
    .cnt  (meas_cnt),
    .hit  (meas_hit),
    .code (meas_code)
  );

  assign meas = '{vld: meas_vld, hit: meas_hit, code: meas_code};

  rate_qualifier #(
    .QUAL_FRAMES (QUAL_FRAMES),
    .STREAK_W    (STREAK_W)
  ) i_qual (
    .clk        (mclk),
    .rst_n      (m_rst_n),
    .meas       (meas),
    .rate_valid (rate_valid),
    .rate_code  (code_w)
  );

  assign rate_code = code_w;

  mclk_loss_monitor #(
    .LOSS_LIMIT (LOSS_LIMIT),
    .LOSS_W     (LOSS_W)
  ) i_loss (
    .mclk        (mclk),
    .mclk_arst_n (rst_n),
    .ref_clk     (ref_clk),
    .ref_rst_n   (ref_rst_n),
    .clk_lost    (clk_lost)
  );
endmodule

// File: rtl/clk_rate_detect_checker.sv
`timescale 1ns/1ps
module clk_rate_detect_checker (
  input logic       mclk,
  input logic       ref_clk,
  input logic       rst_n,
  input logic       fsync,
  input logic [1:0] rate_code,
  input logic       rate_valid,
  input logic       clk_lost,
  input logic       meas_vld,
  input logic       meas_hit
);
  // R9: a lost master clock never coexists with a valid rate
  assert_lost_blocks_valid_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clk_lost |-> !rate_valid);

  // R3: valid can only rise right after a frame-sync rising edge
  assert_valid_on_edge_R3: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(rate_valid) |-> ($past(fsync) && !$past(fsync, 2)));

  // R6: code frozen while valid is held
  assert_code_stable_R6: assert property (@(posedge mclk) disable iff (!rst_n)
    (rate_valid && $past(rate_valid)) |-> $stable(rate_code));

  // R4: an out-of-set measurement drops valid
  assert_miss_clears_R4: assert property (@(posedge mclk) disable iff (!rst_n)
    (meas_vld && !meas_hit) |=> !rate_valid);
endmodule

bind clk_rate_detect clk_rate_detect_checker i_chk (
  .mclk       (mclk),
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .fsync      (fsync),
  .rate_code  (rate_code),
  .rate_valid (rate_valid),
  .clk_lost   (clk_lost),
  .meas_vld   (meas_vld),
  .meas_hit   (meas_hit)
);

// File: tb/test_clk_rate_detect.sv
`timescale 1ns/1ps
module test_clk_rate_detect;
  localparam int LOSS_LIMIT = 200;

  logic       mclk;
  logic       ref_clk;
  logic       rst_n;
  logic       fsync;
  logic [1:0] rate_code;
  logic       rate_valid;
  logic       clk_lost;
  logic       mclk_run;

  int total;
  int bad;
  bit done;

  // bench model of the qualification
  bit   m_seen;
  int   m_last_p;
  int   m_streak;
  int   m_cand;
  bit   m_valid;
  int   rates [4] = '{192, 256, 512, 1024};

  clk_rate_detect #(.LOSS_LIMIT(LOSS_LIMIT)) i_clk_rate_detect (
    .mclk       (mclk),
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .rate_code  (rate_code),
    .rate_valid (rate_valid),
    .clk_lost   (clk_lost)
  );

  initial ref_clk = 1'b0;
  always #2 ref_clk = ~ref_clk;

  initial begin
    mclk = 1'b0;
    forever begin
      #4;
      if (mclk_run || mclk) mclk = ~mclk;
    end
  end

  function automatic int cls(int p);
    if (p == 192 || p == 193) return 0;
    if (p == 256)  return 1;
    if (p == 512)  return 2;
    if (p == 1024) return 3;
    return -1;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_seen = 0; m_streak = 0; m_cand = 0; m_valid = 0; m_last_p = 0;
  endtask

  task automatic model_edge();
    int c;
    if (m_seen) begin
      c = cls(m_last_p);
      if (c < 0) begin
        m_streak = 0; m_valid = 0;
      end else if (m_streak == 0 || c != m_cand) begin
        m_cand = c; m_streak = 1; m_valid = 0;
      end else if (m_streak < 4) begin
        m_streak++;
        if (m_streak == 4) m_valid = 1;
      end
    end
    m_seen = 1;
  endtask

  // one frame of p master cycles, sync high for w cycles (w < p)
  task automatic send_frame(int p, int w, string tag);
    @(negedge mclk) fsync = 1'b1;
    @(negedge mclk);
    model_edge();
    m_last_p = p;
    chk(tag, "rate_valid after edge", {31'd0, rate_valid}, {31'd0, m_valid});
    if (m_valid) chk(tag, "rate_code after edge", {30'd0, rate_code}, m_cand);
    if (w == 1) fsync = 1'b0;
    for (int j = 2; j < p; j++) begin
      @(negedge mclk);
      if (j == w) fsync = 1'b0;
      if (j == p / 2 && m_valid)
        chk("R6", "rate_code mid-frame", {30'd0, rate_code}, m_cand);
    end
  endtask

  initial begin
    #750us;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed_d, pick, run, p, w;
    seed_d = $urandom(32'd5113);
    total = 0; bad = 0; done = 0;
    model_reset();
    rst_n = 1'b0; fsync = 1'b0; mclk_run = 1'b1;
    repeat (6) @(posedge ref_clk);
    @(negedge ref_clk) rst_n = 1'b1;
    repeat (10) @(negedge mclk);

    chk("R1", "rate_valid", {31'd0, rate_valid}, 0);
    chk("R1", "clk_lost",   {31'd0, clk_lost}, 0);
    chk("R1", "rate_code",  {30'd0, rate_code}, 0);

    // R3 / R2: qualify each rate in turn
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 5; k++) send_frame(rates[r], 1, "R3");
    // R2: 1.544 MHz count keeps code 0
    for (int k = 0; k < 5; k++) send_frame(192, 1, "R2");
    for (int k = 0; k < 3; k++) send_frame(193, 1, "R2");
    for (int k = 0; k < 2; k++) send_frame(192, 1, "R2");

    // R5: rate change on a qualified stream, then requalify
    for (int k = 0; k < 5; k++) send_frame(512, 2, "R5");
    for (int k = 0; k < 5; k++) send_frame(256, 1, "R5");
    // R5: change lands on the frame that would have qualified
    for (int k = 0; k < 3; k++) send_frame(512, 1, "R5");
    for (int k = 0; k < 5; k++) send_frame(256, 1, "R5");

    // R4: out-of-set period and saturated period
    send_frame(300, 1, "R4");
    for (int k = 0; k < 5; k++) send_frame(256, 1, "R4");
    send_frame(1100, 1, "R4");
    for (int k = 0; k < 3; k++) send_frame(256, 1, "R4");
    send_frame(256, 1, "R4");

    // R7: long frame sync
    for (int k = 0; k < 6; k++) send_frame(512, 3, "R7");

    // R8 / R9: stop the master clock while valid
    for (int k = 0; k < 5; k++) send_frame(256, 1, "R9");
    chk("R9", "valid before stop", {31'd0, rate_valid}, 1);
    mclk_run = 1'b0;
    repeat (LOSS_LIMIT - 20) @(negedge ref_clk);
    chk("R8", "clk_lost early", {31'd0, clk_lost}, 0);
    repeat (40) @(negedge ref_clk);
    chk("R8", "clk_lost set", {31'd0, clk_lost}, 1);
    chk("R9", "valid while lost", {31'd0, rate_valid}, 0);
    mclk_run = 1'b1;
    repeat (20) @(negedge mclk);
    chk("R8", "clk_lost cleared", {31'd0, clk_lost}, 0);
    chk("R9", "valid after restart", {31'd0, rate_valid}, 0);
    model_reset();
    for (int k = 0; k < 6; k++) send_frame(256, 1, "R9");

    // constrained random mix
    run = 0; pick = 0;
    for (int f = 0; f < 40; f++) begin
      if (run == 0) begin
        pick = int'($urandom % 4);
        run  = 2 + int'($urandom % 6);
      end
      if ($urandom % 8 == 0) begin
        p = 150 + int'($urandom % 1000);
        if (cls(p) >= 0) p = p + 7;
      end else begin
        p = rates[pick];
        if (pick == 0 && ($urandom % 2 == 1)) p = 193;
      end
      w = 1 + int'($urandom % 3);
      send_frame(p, w, "R3");
      run--;
    end

    done = 1;
    summary();
    $finish;
  end
endmodule